// File: doc/BRIEF.md
# Unanimous-Vote Input Deglitcher

This block cleans up a raw asynchronous serial input before a frame receiver looks at it. The pin first passes through a synchroniser chain. A free-running prescaler then takes one sample of the synchronised level every `SAMPLE_DIV` clocks and shifts it into a window of the last `NUM_SAMPLES` samples. The filtered output moves to a new level only when every sample in that window holds that level. While the samples disagree, the output keeps its old value.

Because all samples must agree, the window should cover only a fraction of a bit period, roughly a quarter of a bit, and not a whole bit. With the defaults of 5 samples spaced 16 clocks apart, the window spans 80 clocks. Short spikes never reach the output. A real level change arrives after a bounded delay that can be calculated in advance. While reset is held, the output sits at the line's idle level.

Top module: `pin_deglitch`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `filt_o` equals the `IDLE_LEVEL` parameter (1 by default, a high idle line).
- R2: `filt_o` changes to a level L only on the cycle after the sample window came to hold L in every one of its `NUM_SAMPLES` positions.
- R3: While the sample window holds both 0s and 1s, `filt_o` does not change.
- R4: The window takes exactly one new sample every `SAMPLE_DIV` clocks. The first sample is taken `SAMPLE_DIV` clocks after reset is released. Each sample is the raw level delayed by the `SYNC_STAGES`-flop synchroniser.
- R5: A pulse on `raw_i` away from the current output level is suppressed, so `filt_o` does not move, when the pulse lasts at most `(NUM_SAMPLES-1)*SAMPLE_DIV` clocks and is followed by a return to the old level. This holds for either pulse polarity and for any prescaler phase.
- R6: A new level on `raw_i` that is held for at least `NUM_SAMPLES*SAMPLE_DIV` clocks appears on `filt_o` within `NUM_SAMPLES*SAMPLE_DIV + SYNC_STAGES + 1` clock edges of the first edge that sees it. This holds for either polarity and for any prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_i | input | 1 | Raw input pin level, asynchronous to `clk` |
| filt_o | output | 1 | Filtered level, registered |

## Verification
The assertions assume that `raw_i` is either already synchronous or passes through the synchroniser, so the sampled level stays free of metastability. The bench drives `raw_i` only on the falling clock edge, which keeps it within that assumption. The bench sweeps pulse widths across every prescaler phase and both line polarities on a reduced configuration, and each step is compared against a cycle model of the sampling schedule. The widths at the suppression limit and at the pass limit both fall inside that sweep.

// File: rtl/dg_pkg.sv
`timescale 1ns/1ps
package dg_pkg;
  // Decision taken by the voter for the current window contents.
  typedef enum logic [1:0] {
    VOTE_HOLD = 2'd0,
    VOTE_LOW  = 2'd1,
    VOTE_HIGH = 2'd2
  } vote_e;

  function automatic int unsigned cnt_width(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction
endpackage

// File: rtl/dg_sync.sv
`timescale 1ns/1ps
module dg_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= IDLE;
        else     chain <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{IDLE}};
        else     chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dg_prescale.sv
`timescale 1ns/1ps
module dg_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int unsigned CW = dg_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dg_vote.sv
`timescale 1ns/1ps
module dg_vote #(
  parameter int unsigned N    = 5,
  parameter logic        IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         d_i,
  output logic [N-1:0] hist_o,
  output logic         q_o
);
  import dg_pkg::*;

  logic [N-1:0] hist;
  vote_e        verdict;
  logic         q;

  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)         hist <= IDLE;
        else if (tick_i) hist <= d_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)         hist <= {N{IDLE}};
        else if (tick_i) hist <= {hist[N-2:0], d_i};
      end
    end
  endgenerate

  always_comb begin
    if (&hist)       verdict = VOTE_HIGH;
    else if (~|hist) verdict = VOTE_LOW;
    else             verdict = VOTE_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= IDLE;
    else begin
      case (verdict)
        VOTE_HIGH: q <= 1'b1;
        VOTE_LOW:  q <= 1'b0;
        default:   q <= q;
      endcase
    end
  end

  assign hist_o = hist;
  assign q_o    = q;
endmodule

// File: rtl/pin_deglitch.sv
`timescale 1ns/1ps
module pin_deglitch #(
  parameter int unsigned SAMPLE_DIV  = 16,
  parameter int unsigned NUM_SAMPLES = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic filt_o
);
  logic                   synced;
  logic                   tick_w;
  logic [NUM_SAMPLES-1:0] hist_w;

  dg_sync #(.STAGES(SYNC_STAGES), .IDLE(IDLE_LEVEL)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_i), .q_o(synced)
  );

  dg_prescale #(.DIV(SAMPLE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick_w)
  );

  dg_vote #(.N(NUM_SAMPLES), .IDLE(IDLE_LEVEL)) u_vote (
    .clk(clk), .rst(rst), .tick_i(tick_w), .d_i(synced),
    .hist_o(hist_w), .q_o(filt_o)
  );
endmodule

// File: rtl/pin_deglitch_chk.sv
`timescale 1ns/1ps
module pin_deglitch_chk #(
  parameter int unsigned SAMPLE_DIV  = 16,
  parameter int unsigned NUM_SAMPLES = 5,
  parameter logic        IDLE_LEVEL  = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick,
  input logic [NUM_SAMPLES-1:0] hist,
  input logic                   filt
);
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (rst)       gap <= 0;
    else if (tick) gap <= 0;
    else           gap <= gap + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> filt == IDLE_LEVEL);

  // R2
  unanimous_change_chk: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(hist) == {NUM_SAMPLES{filt}}));

  // R3
  mixed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((|hist) && !(&hist)) |=> $stable(filt));

  // R4
  sample_period_chk: assert property (@(posedge clk) disable iff (rst)
    tick == (gap == SAMPLE_DIV - 1));
endmodule

bind pin_deglitch pin_deglitch_chk #(
  .SAMPLE_DIV(SAMPLE_DIV), .NUM_SAMPLES(NUM_SAMPLES), .IDLE_LEVEL(IDLE_LEVEL)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .hist(hist_w), .filt(filt_o)
);

// File: tb/test_pin_deglitch.sv
`timescale 1ns/1ps
module test_pin_deglitch;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int N    = 3;
  localparam int SYNC = 2;
  localparam bit IDLE = 1'b1;
  localparam int SUPPRESS_MAX = (N - 1) * DIV;
  localparam int PASS_MIN     = N * DIV;
  localparam int LAT_MAX      = N * DIV + SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_i = IDLE;
  logic filt_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  // bench-side cycle model of the sampling schedule
  int         m_cnt = 0;
  bit [SYNC-1:0] m_sync = {SYNC{IDLE}};
  bit [N-1:0] m_win = {N{IDLE}};
  bit         m_q = IDLE;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_deglitch #(.SAMPLE_DIV(DIV), .NUM_SAMPLES(N), .SYNC_STAGES(SYNC),
                 .IDLE_LEVEL(IDLE)) i_pin_deglitch (
    .clk(clk), .rst(rst), .raw_i(raw_i), .filt_o(filt_o)
  );

  task automatic model_edge(input bit r);
    bit take;
    bit nq;
    take = (m_cnt == DIV - 1);
    nq = (&m_win) ? 1'b1 : ((~|m_win) ? 1'b0 : m_q);
    if (take) m_win = {m_win[N-2:0], m_sync[SYNC-1]};
    m_sync = {m_sync[SYNC-2:0], r};
    m_cnt = take ? 0 : m_cnt + 1;
    m_q = nq;
  endtask

  task automatic step(input bit r);
    raw_i = r;
    @(posedge clk);
    model_edge(r);
    @(negedge clk);
    cyc++;
    vectors++;
    // R2 R3 R4: per-cycle comparison against the sampling model
    if (filt_o !== m_q) begin
      fails++;
      $display("FAIL R2 R3 R4 cycle %0d: filt_o=%b expected %b", cyc, filt_o, m_q);
    end
  endtask

  task automatic run_pulse(input bit base, input int ph, input int w);
    int start;
    int first;
    repeat (PASS_MIN + 10) step(base);
    while (m_cnt != ph) step(base);
    start = cyc;
    first = -1;
    for (int i = 0; i < w; i++) begin
      step(~base);
      if (first < 0 && filt_o !== base) first = cyc - start;
    end
    for (int i = 0; i < PASS_MIN + 10; i++) begin
      step(base);
      if (first < 0 && filt_o !== base) first = cyc - start;
    end
    vectors++;
    if (w <= SUPPRESS_MAX && first >= 0) begin
      fails++;
      $display("FAIL R5 base=%b phase=%0d width=%0d: output moved at %0d, expected no move",
               base, ph, w, first);
    end
    if (w >= PASS_MIN && (first < 0 || first > LAT_MAX)) begin
      fails++;
      $display("FAIL R6 base=%b phase=%0d width=%0d: latency %0d, expected 1..%0d",
               base, ph, w, first, LAT_MAX);
    end
    vectors++;
    if (filt_o !== base) begin
      fails++;
      $display("FAIL R6 base=%b width=%0d: final level %b, expected %b", base, w, filt_o, base);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    raw_i = ~IDLE;
    repeat (3) @(negedge clk);
    vectors++;
    // R1: output at idle level while in reset
    if (filt_o !== IDLE) begin
      fails++;
      $display("FAIL R1 in reset: filt_o=%b expected %b", filt_o, IDLE);
    end
    rst = 1'b0;
    step(~IDLE);
    vectors++;
    // R1: still idle on first cycle after reset
    if (filt_o !== IDLE) begin
      fails++;
      $display("FAIL R1 after reset: filt_o=%b expected %b", filt_o, IDLE);
    end
    for (int b = 0; b < 2; b++) begin
      for (int ph = 0; ph < DIV; ph++) begin
        for (int w = 1; w <= PASS_MIN + 4; w++) begin
          run_pulse((b == 0) ? IDLE : ~IDLE, ph, w);
        end
      end
    end
    // R3: alternating pattern keeps window mixed
    for (int i = 0; i < 40; i++) step(((i / DIV) % 2) == 0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule